// File: doc/BRIEF.md
# Nonvolatile Write Gate with Block Protection

This block sits behind a serial bus front end. It decides which decoded write transactions may reach a control register file and a memory array. The front end hands it single-cycle events of three kinds. A status write carries a data byte. A control register write carries a device byte, a start address and a byte count. An array write carries an address. The block holds two write-enable latches: a general one, `wel`, and a register one, `rwel`. Control register writes need a two-step unlock before the gate lets them through.

An accepted control register write starts a nonvolatile busy period. Its length is a parameter counted in system clock cycles. While the period runs, every incoming write is refused. When the period ends, the register latch drops, so the unlock must be repeated before the next control register write. Array writes are screened against a 3-bit protect code that covers either an upper fraction of the array or a number of leading pages.

The accept outputs are one-cycle pulses. The storage side uses them to commit data.

Top module: `nvw_gate`

## Requirements
- R1: After reset, `wel_o`, `rwel_o`, `busy_o`, `cr_accept_o` and `ar_accept_o` are all 0.
- R2: A status write of 02h sets `wel_o` and leaves `rwel_o` unchanged. The new value is visible the cycle after the event.
- R3: A status write of 06h sets both `wel_o` and `rwel_o`.
- R4: A status write of any value other than 02h or 06h clears both `wel_o` and `rwel_o`.
- R5: A control register write pulses `cr_accept_o` high for one cycle, the cycle after the event, only when all of the following hold: `wel_o` and `rwel_o` are both 1, the device byte equals DEh, the start address is below `CR_REGS`, the byte count is between 1 and 8 inclusive, and the block is not busy. Any other control register write produces no pulse and starts no busy period.
- R6: An accepted control register write raises `busy_o` in the same cycle as `cr_accept_o`. `busy_o` stays high for exactly `BUSY_CYCLES` cycles. When it falls, `rwel_o` is cleared and `wel_o` is kept.
- R7: While `busy_o` is 1, status, control register and array writes all have no effect on the latches or on the accept outputs.
- R8: The array address is 11 bits wide with 64-byte pages. The protect code `bp_i` marks these addresses as protected: 000 none; 001 600h–7FFh; 010 400h–7FFh; 011 all; 100 000h–03Fh; 101 000h–07Fh; 110 000h–0FFh; 111 000h–1FFh.
- R9: An array write pulses `ar_accept_o` for one cycle, the cycle after the event, exactly when the block is not busy and the address is not protected. An array write to a protected address gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sr_wr_i | input | 1 | Status write event |
| sr_data_i | input | 8 | Status write data byte |
| cr_wr_i | input | 1 | Control register write event |
| cr_dev_i | input | 8 | Device byte of the control register write |
| cr_addr_i | input | 8 | Start address in the control register file |
| cr_len_i | input | 4 | Number of data bytes |
| ar_wr_i | input | 1 | Array write event |
| ar_addr_i | input | 11 | Array byte address |
| bp_i | input | 3 | Block protect code |
| wel_o | output | 1 | General write-enable latch |
| rwel_o | output | 1 | Register write-enable latch |
| busy_o | output | 1 | Nonvolatile cycle in progress |
| cr_accept_o | output | 1 | Control register write accepted (pulse) |
| ar_accept_o | output | 1 | Array write accepted (pulse) |

## Verification
Every result is registered once. The latch values and the accept pulses therefore appear one cycle after the event, and `busy_o` rises in that same cycle. The bench drives each event on a falling edge, holds it for one cycle, and samples the outputs on the next falling edge, so each comparison falls in the cycle where the result is due. The busy length is measured by counting falling edges from the accept pulse until `busy_o` drops, and the count is compared against `BUSY_CYCLES`. The array sweep covers every address under every protect code, and the control register sweep covers start addresses and byte counts on both sides of each limit.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  localparam logic [7:0] CR_DEV_ID  = 8'hDE;
  localparam logic [7:0] SR_SET_WEL = 8'h02;
  localparam logic [7:0] SR_SET_ALL = 8'h06;
  localparam int unsigned CR_MAX_LEN = 8;

  typedef enum logic [2:0] {
    BP_NONE  = 3'b000,
    BP_QUART = 3'b001,
    BP_HALF  = 3'b010,
    BP_ALL   = 3'b011,
    BP_PG1   = 3'b100,
    BP_PG2   = 3'b101,
    BP_PG4   = 3'b110,
    BP_PG8   = 3'b111
  } bp_code_e;
endpackage

// File: rtl/nvw_timer.sv
module nvw_timer #(
  parameter int unsigned CYCLES = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      cnt_q  <= LOAD;
      busy_q <= 1'b1;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_done_ends_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/nvw_latch.sv
module nvw_latch
  import nvw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sr_wr_i,
  input  logic [7:0] sr_data_i,
  input  logic       busy_i,
  input  logic       done_i,
  output logic       wel_o,
  output logic       rwel_o
);
  logic wel_q, rwel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
    end else if (done_i) begin
      rwel_q <= 1'b0;
    end else if (sr_wr_i && !busy_i) begin
      unique case (sr_data_i)
        SR_SET_WEL: wel_q <= 1'b1;
        SR_SET_ALL: begin
          wel_q  <= 1'b1;
          rwel_q <= 1'b1;
        end
        default: begin
          wel_q  <= 1'b0;
          rwel_q <= 1'b0;
        end
      endcase
    end
  end

  assign wel_o  = wel_q;
  assign rwel_o = rwel_q;

  assert_busy_holds_wel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i) |=> (wel_o == $past(wel_o)) && (rwel_o == $past(rwel_o)));
  assert_bad_byte_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_wr_i && !busy_i && sr_data_i != SR_SET_WEL && sr_data_i != SR_SET_ALL)
      |=> !wel_o && !rwel_o);
endmodule

// File: rtl/nvw_protect.sv
module nvw_protect
  import nvw_pkg::*;
#(
  parameter int unsigned AW      = 11,
  parameter int unsigned PAGE_AW = 6
) (
  input  logic [2:0]    bp_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  always_comb begin
    unique case (bp_code_e'(bp_i))
      BP_NONE:  hit_o = 1'b0;
      BP_QUART: hit_o = &addr_i[AW-1 -: 2];
      BP_HALF:  hit_o = addr_i[AW-1];
      BP_ALL:   hit_o = 1'b1;
      default:  hit_o = (addr_i >> (PAGE_AW + 32'(bp_i[1:0]))) == '0;
    endcase
  end

  always_comb begin
    if (bp_i == 3'b000) assert_none_open_R8: assert (!hit_o);
  end
endmodule

// File: rtl/nvw_gate.sv
module nvw_gate
  import nvw_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 1000000,
  parameter int unsigned CR_REGS     = 8,
  parameter int unsigned CR_AW       = 8,
  parameter int unsigned AR_AW       = 11,
  parameter int unsigned PAGE_AW     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sr_wr_i,
  input  logic [7:0]       sr_data_i,
  input  logic             cr_wr_i,
  input  logic [7:0]       cr_dev_i,
  input  logic [CR_AW-1:0] cr_addr_i,
  input  logic [3:0]       cr_len_i,
  input  logic             ar_wr_i,
  input  logic [AR_AW-1:0] ar_addr_i,
  input  logic [2:0]       bp_i,
  output logic             wel_o,
  output logic             rwel_o,
  output logic             busy_o,
  output logic             cr_accept_o,
  output logic             ar_accept_o
);
  logic busy, done, hit, cr_ok, ar_ok;
  logic cr_acc_q, ar_acc_q;

  nvw_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(cr_ok), .busy_o(busy), .done_o(done)
  );

  nvw_latch u_latch (
    .clk_i, .rst_ni, .sr_wr_i, .sr_data_i,
    .busy_i(busy), .done_i(done), .wel_o, .rwel_o
  );

  nvw_protect #(.AW(AR_AW), .PAGE_AW(PAGE_AW)) u_prot (
    .bp_i, .addr_i(ar_addr_i), .hit_o(hit)
  );

  assign cr_ok = cr_wr_i && !busy && wel_o && rwel_o
              && (cr_dev_i == CR_DEV_ID)
              && (32'(cr_addr_i) < CR_REGS)
              && (cr_len_i != '0) && (32'(cr_len_i) <= CR_MAX_LEN);
  assign ar_ok = ar_wr_i && !busy && !hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr_acc_q <= 1'b0;
      ar_acc_q <= 1'b0;
    end else begin
      cr_acc_q <= cr_ok;
      ar_acc_q <= ar_ok;
    end
  end

  assign busy_o      = busy;
  assign cr_accept_o = cr_acc_q;
  assign ar_accept_o = ar_acc_q;

  assert_cr_needs_unlock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_accept_o |-> $past(wel_o) && $past(rwel_o));
  assert_cr_starts_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_accept_o |-> busy_o && !$past(busy_o));
  assert_busy_end_relocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !rwel_o);
  assert_busy_blocks_array_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_accept_o |-> !$past(busy_o));
  assert_full_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_accept_o |-> $past(bp_i) != 3'b011);
endmodule

// File: tb/sim_nvw_gate.sv
`timescale 1ns/1ps
module sim_nvw_gate;
  localparam int unsigned BUSY = 12;
  localparam int unsigned REGS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sr_wr = 0, cr_wr = 0, ar_wr = 0;
  logic [7:0] sr_data = 0, cr_dev = 0, cr_addr = 0;
  logic [3:0] cr_len = 0;
  logic [10:0] ar_addr = 0;
  logic [2:0] bp = 0;
  logic wel, rwel, busy, cr_acc, ar_acc;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  nvw_gate #(.BUSY_CYCLES(BUSY), .CR_REGS(REGS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sr_wr_i(sr_wr), .sr_data_i(sr_data),
    .cr_wr_i(cr_wr), .cr_dev_i(cr_dev), .cr_addr_i(cr_addr), .cr_len_i(cr_len),
    .ar_wr_i(ar_wr), .ar_addr_i(ar_addr), .bp_i(bp),
    .wel_o(wel), .rwel_o(rwel), .busy_o(busy),
    .cr_accept_o(cr_acc), .ar_accept_o(ar_acc)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // Each task is entered just after a falling edge; it drives, waits one cycle, samples.
  task automatic do_sr(input logic [7:0] d);
    sr_wr = 1; sr_data = d;
    @(negedge clk);
    sr_wr = 0;
  endtask

  task automatic do_cr(input logic [7:0] dev, input logic [7:0] a, input logic [3:0] n);
    cr_wr = 1; cr_dev = dev; cr_addr = a; cr_len = n;
    @(negedge clk);
    cr_wr = 0;
  endtask

  task automatic do_ar(input logic [10:0] a);
    ar_wr = 1; ar_addr = a;
    @(negedge clk);
    ar_wr = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 4 * BUSY && busy; g++) @(negedge clk);
  endtask

  function automatic logic prot_ref(input int code, input int a);
    case (code)
      0: return 1'b0;
      1: return a >= 'h600;
      2: return a >= 'h400;
      3: return 1'b1;
      4: return a < 64;
      5: return a < 128;
      6: return a < 256;
      default: return a < 512;
    endcase
  endfunction

  initial begin
    int k;
    repeat (3) @(negedge clk);
    chk(wel, 0, "R1 wel"); chk(rwel, 0, "R1 rwel"); chk(busy, 0, "R1 busy");
    chk(cr_acc, 0, "R1 cr_acc"); chk(ar_acc, 0, "R1 ar_acc");
    rst_n = 1;
    idle();

    // R5: locked write rejected
    do_cr(8'hDE, 0, 1); chk(cr_acc, 0, "R5 locked"); chk(busy, 0, "R5 locked busy");
    // R2
    do_sr(8'h02); chk(wel, 1, "R2 wel"); chk(rwel, 0, "R2 rwel");
    do_cr(8'hDE, 0, 1); chk(cr_acc, 0, "R5 wel only");
    // R3
    do_sr(8'h06); chk(wel, 1, "R3 wel"); chk(rwel, 1, "R3 rwel");
    do_sr(8'h02); chk(rwel, 1, "R2 rwel kept");
    // R4
    do_sr(8'h07); chk(wel, 0, "R4 wel"); chk(rwel, 0, "R4 rwel");
    do_sr(8'h06); do_sr(8'h00); chk(wel, 0, "R4 zero wel"); chk(rwel, 0, "R4 zero rwel");
    // R5 wrong device byte
    do_sr(8'h06); do_cr(8'hDF, 0, 1); chk(cr_acc, 0, "R5 device"); chk(busy, 0, "R5 device busy");

    // R5 sweep of address and length
    for (int a = 0; a < 12; a++) begin
      for (int n = 0; n < 10; n++) begin
        logic ok;
        ok = (a < REGS) && (n >= 1) && (n <= 8);
        do_sr(8'h06);
        do_cr(8'hDE, 8'(a), 4'(n));
        chk(cr_acc, ok, "R5 sweep accept");
        chk(busy, ok, "R5 sweep busy");
        wait_idle();
      end
    end

    // R6 / R7: busy length, relock and blocking
    do_sr(8'h06);
    do_cr(8'hDE, 3, 8); chk(cr_acc, 1, "R6 accept"); chk(busy, 1, "R6 busy rise");
    k = 0;
    do_sr(8'h00); k++; chk(wel, 1, "R7 sr ignored wel"); chk(rwel, 1, "R7 sr ignored rwel");
    bp = 0;
    do_ar(11'h010); k++; chk(ar_acc, 0, "R7 array blocked");
    do_cr(8'hDE, 1, 1); k++; chk(cr_acc, 0, "R7 cr blocked");
    while (busy && k < 4 * BUSY) begin @(negedge clk); k++; end
    n_chk++;
    if (k != BUSY) begin
      n_fail++;
      $display("FAIL R6 busy length: actual %0d expected %0d", k, BUSY);
    end
    chk(rwel, 0, "R6 relock rwel"); chk(wel, 1, "R6 wel kept");
    do_cr(8'hDE, 0, 1); chk(cr_acc, 0, "R6 relocked reject");

    // R8 / R9: full protect sweep
    for (int c = 0; c < 8; c++) begin
      bp = 3'(c);
      for (int a = 0; a < 2048; a++) begin
        do_ar(11'(a));
        chk(ar_acc, !prot_ref(c, a), "R8 R9 protect map");
      end
    end
    idle(); chk(ar_acc, 0, "R9 single pulse");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule